// File: doc/BRIEF.md
# Shadowed Nonvolatile Configuration Register

This block holds a 16-bit configuration word in two layers: a volatile working copy that drives the block's outputs, and a nonvolatile shadow copy of the same width, bit for bit. A serial command front end, outside the block, decodes instructions and hands over single-cycle strobes. One strobe loads a new word into the working copy. One arms a write-enable latch. One reports a write to a separate general-purpose memory array. The shadow copy is never written directly. It takes the working copy only when an armed write-enable is followed by a general-array write, and the address and data of that write play no part in what is stored.

The power domain is modelled by `pwr_on`. While it is low, the working copy is lost and reads as zero. In the first clock with power present, the shadow is recalled into the working copy, and commands are accepted only after that. A store runs for `STORE_CYCLES` clocks with `busy` high, and the shadow is committed at the end. The shadow flops are set to their shipped contents only by `nv_init_n`, which stands for the part's initial programming. From the working copy the block decodes a cell-count bit and a 2-bit threshold select, and gives the threshold level in millivolts.

Top module: `cfg_shadow_reg`

## Requirements
- R1: In the first clock edge that samples `pwr_on` high after it was low, the working copy is loaded from the shadow and `busy` is high. Command strobes sampled at that edge are ignored.
- R2: While `pwr_on` is low, `cfg_q` reads 0, `busy` is high and the write-enable latch is cleared.
- R3: A write-configuration strobe accepted while ready sets `cfg_q` to `cfg_wdata` at the next edge and leaves the shadow unchanged, so a power cycle restores the last stored word.
- R4: A general-array write while the write-enable latch is set starts a store. `busy` is then high for exactly `STORE_CYCLES` (default 8) cycles, after which the shadow equals the working copy.
- R5: The address and data of the general-array write have no effect on the stored value.
- R6: A general-array write without a set write-enable latch starts no store and leaves `busy` low.
- R7: Any general-array write and any power loss clear the write-enable latch, so each store needs a fresh write-enable.
- R8: Write-configuration and write-enable strobes that arrive while `busy` is high are ignored.
- R9: Power lost during a store aborts it, and the shadow keeps its previous value.
- R10: When several strobes coincide, only one is acted on, in the priority general-array write, then write-enable, then write-configuration.
- R11: Bit 8 of the word selects the cell count: 1 gives 4 and 0 gives 3. Bits [1:0] select the threshold: 00, 01, 10 and 11 give 500, 800, 1100 and 1400 mV.
- R12: While `nv_init_n` is low, the shadow is set to 16'h0100 (four cells, code 00), the working copy to 0, and the block waits for recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init_n | input | 1 | Asynchronous, active-low initial programming of the shadow |
| pwr_on | input | 1 | Power present; low means the working copy is lost |
| cmd_wcfg | input | 1 | Write-configuration strobe |
| cfg_wdata | input | 16 | Word for write-configuration |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_arr_wr | input | 1 | General-array write strobe |
| arr_addr | input | ARR_AW (9) | Address of the general-array write (ignored) |
| arr_wdata | input | 8 | Data of the general-array write (ignored) |
| cfg_q | output | 16 | Live working copy |
| cell_count | output | 3 | Decoded cell count (3 or 4) |
| vth_sel | output | 2 | Threshold select field |
| vth_mv | output | 11 | Threshold level in millivolts |
| busy | output | 1 | High during power-off, recall and store |

## Verification
The store sequence is tried with three input patterns. The first is an enabled array write to the top address with nonzero data. The second is an enabled array write to address 0 with zero data, which shows that the stored word does not depend on either field. The third is a bare array write, which separates a real store from a mere strobe. Power cycles placed after plain configuration writes, after a completed store and in the middle of a store tell apart a working-only update, a committed shadow and an aborted commit. Coinciding strobes, and strobes sent while busy, expose the priority order and the freeze.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;

    localparam int CFG_W = 16;

    typedef enum logic [1:0] {
        PH_RECALL = 2'd0,
        PH_READY  = 2'd1,
        PH_STORE  = 2'd2
    } phase_e;

endpackage

// File: rtl/cfgsh_seq.sv
module cfgsh_seq
    import cfgsh_pkg::*;
#(
    parameter int STORE_CYCLES = 8
) (
    input  logic   clk,
    input  logic   nv_init_n,
    input  logic   pwr_on,
    input  logic   cmd_wcfg,
    input  logic   cmd_wren,
    input  logic   cmd_arr_wr,
    output phase_e phase_o,
    output logic   busy_o,
    output logic   recall_ld_o,
    output logic   commit_o,
    output logic   wcfg_acc_o
);

    localparam int CW = $clog2(STORE_CYCLES + 1);

    typedef struct packed {
        phase_e        ph;
        logic          wel;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic recall_ld, commit, wcfg_acc;

    always_comb begin
        seq_d     = seq_q;
        recall_ld = 1'b0;
        commit    = 1'b0;
        wcfg_acc  = 1'b0;
        if (!pwr_on) begin
            seq_d.ph  = PH_RECALL;
            seq_d.wel = 1'b0;
            seq_d.cnt = '0;
        end else begin
            case (seq_q.ph)
                PH_RECALL: begin
                    recall_ld = 1'b1;
                    seq_d.ph  = PH_READY;
                end
                PH_READY: begin
                    if (cmd_arr_wr) begin
                        seq_d.wel = 1'b0;
                        if (seq_q.wel) begin
                            seq_d.ph  = PH_STORE;
                            seq_d.cnt = CW'(STORE_CYCLES - 1);
                        end
                    end else if (cmd_wren) begin
                        seq_d.wel = 1'b1;
                    end else if (cmd_wcfg) begin
                        wcfg_acc = 1'b1;
                    end
                end
                PH_STORE: begin
                    if (seq_q.cnt == '0) begin
                        commit   = 1'b1;
                        seq_d.ph = PH_READY;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                default: seq_d.ph = PH_RECALL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            seq_q.ph  <= PH_RECALL;
            seq_q.wel <= 1'b0;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o     = seq_q.ph;
    assign busy_o      = (seq_q.ph != PH_READY);
    assign recall_ld_o = recall_ld;
    assign commit_o    = commit;
    assign wcfg_acc_o  = wcfg_acc;

    p_wel_clear_r7: assert property (@(posedge clk) disable iff (!nv_init_n)
        (pwr_on && seq_q.ph == PH_READY && cmd_arr_wr) |=> !seq_q.wel);

    p_store_hold_r4: assert property (@(posedge clk) disable iff (!nv_init_n)
        (pwr_on && seq_q.ph == PH_STORE && seq_q.cnt != '0) |=> (seq_q.ph == PH_STORE));

    p_busy_no_wren_r8: assert property (@(posedge clk) disable iff (!nv_init_n)
        (pwr_on && seq_q.ph == PH_STORE) |=> !seq_q.wel);

    p_off_clears_r2: assert property (@(posedge clk) disable iff (!nv_init_n)
        !pwr_on |=> (seq_q.ph == PH_RECALL && !seq_q.wel));

endmodule

// File: rtl/cfgsh_field_dec.sv
module cfgsh_field_dec
    import cfgsh_pkg::*;
#(
    parameter int CELL_BIT = 8,
    parameter int VTH_LSB  = 0,
    parameter int MV_BASE  = 500,
    parameter int MV_STEP  = 300,
    parameter int MV_W     = 11
) (
    input  logic [CFG_W-1:0] cfg_i,
    output logic [2:0]       cell_count_o,
    output logic [1:0]       vth_sel_o,
    output logic [MV_W-1:0]  vth_mv_o
);

    localparam logic [MV_W-1:0] BASE = MV_W'(MV_BASE);
    localparam logic [MV_W-1:0] STEP = MV_W'(MV_STEP);

    logic [1:0] sel;

    always_comb begin
        sel          = cfg_i[VTH_LSB +: 2];
        cell_count_o = cfg_i[CELL_BIT] ? 3'd4 : 3'd3;
        vth_sel_o    = sel;
        vth_mv_o     = BASE + STEP * MV_W'(sel);
    end

endmodule

// File: rtl/cfg_shadow_reg.sv
module cfg_shadow_reg
    import cfgsh_pkg::*;
#(
    parameter int              STORE_CYCLES = 8,
    parameter int              ARR_AW       = 9,
    parameter logic [CFG_W-1:0] NV_DEFAULT  = 16'h0100
) (
    input  logic              clk,
    input  logic              nv_init_n,
    input  logic              pwr_on,
    input  logic              cmd_wcfg,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmd_wren,
    input  logic              cmd_arr_wr,
    input  logic [ARR_AW-1:0] arr_addr,
    input  logic [7:0]        arr_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [2:0]        cell_count,
    output logic [1:0]        vth_sel,
    output logic [10:0]       vth_mv,
    output logic              busy
);

    typedef struct packed {
        logic [CFG_W-1:0] work;
        logic [CFG_W-1:0] shadow;
    } regs_t;

    regs_t  regs_d, regs_q;
    phase_e phase;
    logic   recall_ld, commit, wcfg_acc;

    // The array write's address and data take no part in the store.
    logic unused_arr_bits;
    assign unused_arr_bits = ^{arr_addr, arr_wdata};

    cfgsh_seq #(.STORE_CYCLES(STORE_CYCLES)) u_seq (
        .clk        (clk),
        .nv_init_n  (nv_init_n),
        .pwr_on     (pwr_on),
        .cmd_wcfg   (cmd_wcfg),
        .cmd_wren   (cmd_wren),
        .cmd_arr_wr (cmd_arr_wr),
        .phase_o    (phase),
        .busy_o     (busy),
        .recall_ld_o(recall_ld),
        .commit_o   (commit),
        .wcfg_acc_o (wcfg_acc)
    );

    always_comb begin
        regs_d = regs_q;
        if (!pwr_on)
            regs_d.work = '0;
        else if (recall_ld)
            regs_d.work = regs_q.shadow;
        else if (wcfg_acc)
            regs_d.work = cfg_wdata;
        if (commit)
            regs_d.shadow = regs_q.work;
    end

    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            regs_q.work   <= '0;
            regs_q.shadow <= NV_DEFAULT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_q = regs_q.work;

    cfgsh_field_dec u_dec (
        .cfg_i       (regs_q.work),
        .cell_count_o(cell_count),
        .vth_sel_o   (vth_sel),
        .vth_mv_o    (vth_mv)
    );

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!nv_init_n)
        !commit |=> $stable(regs_q.shadow));

    p_recall_load_r1: assert property (@(posedge clk) disable iff (!nv_init_n)
        (pwr_on && recall_ld) |=> (regs_q.work == $past(regs_q.shadow)));

    p_store_freeze_r8: assert property (@(posedge clk) disable iff (!nv_init_n)
        (pwr_on && phase == PH_STORE) |=> $stable(regs_q.work));

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!nv_init_n)
        commit |=> (regs_q.shadow == $past(regs_q.work)));

endmodule

// File: tb/cfg_shadow_reg_bench.sv
module cfg_shadow_reg_bench;

    localparam int CLK_P = 10;
    localparam int SC    = 8;

    logic        clk = 1'b0;
    logic        nv_init_n = 1'b0;
    logic        pwr_on = 1'b0;
    logic        cmd_wcfg = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cmd_wren = 1'b0;
    logic        cmd_arr_wr = 1'b0;
    logic [8:0]  arr_addr = '0;
    logic [7:0]  arr_wdata = '0;
    logic [15:0] cfg_q;
    logic [2:0]  cell_count;
    logic [1:0]  vth_sel;
    logic [10:0] vth_mv;
    logic        busy;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R12";
    bit    done = 1'b0;

    // reference model state: 0 off/recall, 1 ready, 2 storing
    int          m_ph = 0;
    bit          m_wel = 1'b0;
    int          m_left = 0;
    logic [15:0] m_work = '0;
    logic [15:0] m_shadow = 16'h0100;

    cfg_shadow_reg #(.STORE_CYCLES(SC)) u_cfg_shadow_reg (
        .clk(clk), .nv_init_n(nv_init_n), .pwr_on(pwr_on),
        .cmd_wcfg(cmd_wcfg), .cfg_wdata(cfg_wdata), .cmd_wren(cmd_wren),
        .cmd_arr_wr(cmd_arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .cfg_q(cfg_q), .cell_count(cell_count), .vth_sel(vth_sel),
        .vth_mv(vth_mv), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            m_ph <= 0; m_wel <= 1'b0; m_left <= 0;
            m_work <= '0; m_shadow <= 16'h0100;
        end else if (!pwr_on) begin
            m_ph <= 0; m_wel <= 1'b0; m_work <= '0;
        end else if (m_ph == 0) begin
            m_work <= m_shadow; m_ph <= 1;
        end else if (m_ph == 1) begin
            if (cmd_arr_wr) begin
                m_wel <= 1'b0;
                if (m_wel) begin m_ph <= 2; m_left <= SC; end
            end else if (cmd_wren) m_wel <= 1'b1;
            else if (cmd_wcfg) m_work <= cfg_wdata;
        end else begin
            if (m_left == 1) begin m_shadow <= m_work; m_ph <= 1; end
            m_left <= m_left - 1;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mv_of(logic [15:0] w);
        case (w[1:0])
            2'b00: return 500;
            2'b01: return 800;
            2'b10: return 1100;
            default: return 1400;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "model cfg_q", 32'(cfg_q), 32'(m_work));
            chk(cur_req, "model busy", 32'(busy), 32'(m_ph != 1));
            chk("R11", "model cell_count", 32'(cell_count), m_work[8] ? 32'd4 : 32'd3);
            chk("R11", "model vth_sel", 32'(vth_sel), 32'(m_work[1:0]));
            chk("R11", "model vth_mv", 32'(vth_mv), 32'(mv_of(m_work)));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(logic [15:0] d);
        cmd_wcfg = 1'b1; cfg_wdata = d; step(1); cmd_wcfg = 1'b0;
    endtask

    task automatic wren();
        cmd_wren = 1'b1; step(1); cmd_wren = 1'b0;
    endtask

    task automatic arr_wr(logic [8:0] a, logic [7:0] d);
        cmd_arr_wr = 1'b1; arr_addr = a; arr_wdata = d; step(1); cmd_arr_wr = 1'b0;
    endtask

    task automatic power_cycle();
        pwr_on = 1'b0; step(2); pwr_on = 1'b1; step(1);
    endtask

    task automatic wait_idle();
        while (busy) step(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
        finish_run();
    end

    initial begin
        int k;
        step(3);
        chk("R12", "cfg_q in init", 32'(cfg_q), 32'h0);
        chk("R2", "busy while off", 32'(busy), 32'd1);

        cur_req = "R1";
        nv_init_n = 1'b1; step(1);
        pwr_on = 1'b1; cmd_wcfg = 1'b1; cfg_wdata = 16'hFFFF;
        step(1); cmd_wcfg = 1'b0;
        chk("R1", "recall of default", 32'(cfg_q), 32'h0100);
        chk("R12", "default cells", 32'(cell_count), 32'd4);
        chk("R11", "code 00 mv", 32'(vth_mv), 32'd500);
        chk("R1", "ready after recall", 32'(busy), 32'd0);

        cur_req = "R11";
        wcfg(16'h0003);
        chk("R3", "wcfg value", 32'(cfg_q), 32'h0003);
        chk("R11", "three cells", 32'(cell_count), 32'd3);
        chk("R11", "code 11 mv", 32'(vth_mv), 32'd1400);
        wcfg(16'h0101); chk("R11", "code 01 mv", 32'(vth_mv), 32'd800);
        wcfg(16'h0102); chk("R11", "code 10 mv", 32'(vth_mv), 32'd1100);

        cur_req = "R3";
        power_cycle();
        chk("R3", "unstored wcfg lost", 32'(cfg_q), 32'h0100);

        cur_req = "R6";
        wcfg(16'h0002);
        arr_wr(9'h055, 8'h5A);
        chk("R6", "no store without wel", 32'(busy), 32'd0);
        power_cycle();
        chk("R6", "shadow unchanged", 32'(cfg_q), 32'h0100);

        cur_req = "R4";
        wcfg(16'h0002); wren(); arr_wr(9'h1FF, 8'hAA);
        k = 0;
        while (busy) begin
            cmd_wcfg = (k == 1); cfg_wdata = 16'h0003;
            cmd_wren = (k == 3);
            step(1); k++;
        end
        cmd_wcfg = 1'b0; cmd_wren = 1'b0;
        chk("R4", "busy length", 32'(k), 32'(SC));
        chk("R8", "wcfg ignored while busy", 32'(cfg_q), 32'h0002);
        cur_req = "R7";
        arr_wr(9'h000, 8'h00);
        chk("R7", "wel not armed by busy wren", 32'(busy), 32'd0);
        cur_req = "R4";
        power_cycle();
        chk("R4", "stored word recalled", 32'(cfg_q), 32'h0002);

        cur_req = "R5";
        wcfg(16'h0101); wren(); arr_wr(9'h000, 8'h00); wait_idle();
        power_cycle();
        chk("R5", "store independent of addr/data", 32'(cfg_q), 32'h0101);

        cur_req = "R10";
        cmd_wren = 1'b1; cmd_wcfg = 1'b1; cfg_wdata = 16'h0003; step(1);
        cmd_wren = 1'b0;
        chk("R10", "wren wins over wcfg", 32'(cfg_q), 32'h0101);
        cmd_arr_wr = 1'b1; step(1); cmd_arr_wr = 1'b0; cmd_wcfg = 1'b0;
        chk("R10", "array write wins, store starts", 32'(busy), 32'd1);
        chk("R10", "wcfg dropped", 32'(cfg_q), 32'h0101);
        wait_idle();

        cur_req = "R9";
        wcfg(16'h0003); wren(); arr_wr(9'h010, 8'h01); step(3);
        power_cycle();
        chk("R9", "aborted store keeps shadow", 32'(cfg_q), 32'h0101);

        cur_req = "R7";
        wren(); power_cycle(); arr_wr(9'h020, 8'h02);
        chk("R7", "power loss clears wel", 32'(busy), 32'd0);
        step(2);
        finish_run();
    end

endmodule